// File: doc/BRIEF.md
# Ethernet PHY Status and Identifier Register Read Bank

This block is the read side of a 10/100 Ethernet transceiver's management register set. It covers three registers: the basic status word, which has sticky, latch-low and live bits, and the two constant identifier words. The block samples live condition inputs every cycle: link good, auto-negotiation finished, remote fault seen, jabber seen, and the auto-negotiation enable bit from the control register. It keeps the history bits that a management reader must not miss between two polls.

A management front end starts a read by pulsing a one-cycle strobe with a 5-bit register number. One cycle later the block returns the 16-bit word with a valid pulse. A read of the status register returns the history bits as they stood before the read. The clearing effect of that read appears on the following cycle. A condition that arrives in the same cycle as the clearing read is never lost.

Top module: `phy_mgmt_status`

## Requirements
- R1: After synchronous reset, rd_valid is 0 and the remote fault, jabber and link history bits are all 0, so the first status read shows bits 4, 2 and 1 as 0.
- R2: A rd_stb in cycle n gives rd_valid = 1 and the addressed word on rd_data in cycle n+1. rd_valid is 0 in every cycle that does not follow a strobe.
- R3: Status bit 4 (remote fault) becomes 1 in the cycle after fault_in is high. It then stays 1 until a read of register 1 clears it.
- R4: Status bit 1 (jabber) becomes 1 in the cycle after jabber_in is high. It then stays 1 until a read of register 1 clears it.
- R5: Status bit 2 (link) becomes 0 in the cycle after link_ok_in is low. It stays 0 even after link_ok_in returns high, until a read of register 1. That read loads the bit from link_ok_in.
- R6: A status read returns the history bits as they stood before the read. If fault_in or jabber_in is high in the same cycle as the clearing read, the bit stays 1. If link_ok_in is low in that cycle, bit 2 stays 0.
- R7: Status bit 3 reads an_enable_in and bit 5 reads an_done_in, both sampled in the strobe cycle. Bit 0 reads 1, bits 9:6 read 0, and bits 15:10 read the ABILITY parameter (default 6'b011110).
- R8: Register 2 reads 16'h000E.
- R9: Register 3 reads 16'h70C9. This packs OUI tail 6'h1C in bits 15:10, model 6'h0C in bits 9:4 and revision 4'h9 in bits 3:0.
- R10: Every register number other than 1, 2 and 3 reads 16'h0000, and a read of one of them leaves the history bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | One-cycle read request |
| rd_addr | input | 5 | Register number for the read |
| link_ok_in | input | 1 | Live link-good condition |
| an_done_in | input | 1 | Live auto-negotiation complete |
| fault_in | input | 1 | Remote fault seen this cycle |
| jabber_in | input | 1 | Jabber seen this cycle |
| an_enable_in | input | 1 | Auto-negotiation enable bit from the control register |
| rd_data | output | 16 | Read word, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_stb |

## Verification
The assertions assume that every input is synchronous to clk and is sampled only at the rising edge. They also assume that rd_addr matters only in a cycle where rd_stb is high. The stimulus changes all inputs on the falling edge only. It holds the strobe for exactly one cycle per read and draws register numbers from the mapped set together with several unmapped ones. It keeps fault and jabber pulses sparse enough that clearing reads are actually seen, and it also aligns pulses with reads on purpose.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;

    localparam int REG_AW = 5;
    localparam int REG_DW = 16;

    typedef logic [REG_AW-1:0] reg_addr_t;
    typedef logic [REG_DW-1:0] reg_word_t;

    localparam reg_addr_t ADDR_STATUS = 5'd1;
    localparam reg_addr_t ADDR_ID_HI  = 5'd2;
    localparam reg_addr_t ADDR_ID_LO  = 5'd3;

    localparam reg_word_t ID_HI_WORD   = 16'h000E;
    localparam logic [5:0] OUI_TAIL    = 6'h1C;
    localparam logic [5:0] MODEL_NUM   = 6'h0C;
    localparam logic [3:0] REVISION    = 4'h9;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ID_HI  = 2'd2,
        SEL_ID_LO  = 2'd3
    } reg_sel_t;

    typedef struct packed {
        logic an_done;
        logic rfault;
        logic an_able;
        logic link;
        logic jabber;
    } stat_flags_t;

    function automatic reg_sel_t decode_addr(reg_addr_t a);
        case (a)
            ADDR_STATUS: return SEL_STATUS;
            ADDR_ID_HI:  return SEL_ID_HI;
            ADDR_ID_LO:  return SEL_ID_LO;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic reg_word_t pack_status(logic [5:0] abil, stat_flags_t f);
        return {abil, 4'b0000, f.an_done, f.rfault, f.an_able, f.link, f.jabber, 1'b1};
    endfunction

endpackage

// File: rtl/phy_stat_sticky.sv
module phy_stat_sticky #(
    parameter bit HOLD_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic live_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;

    generate
        if (HOLD_LOW) begin : g_low
            always_ff @(posedge clk) begin
                if (rst)        q <= 1'b0;
                else if (clr_i) q <= live_i;
                else            q <= q & live_i;
            end

            AST_LOW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
                !live_i |=> !q);                                  // R5
            AST_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
                (!q && !clr_i) |=> !q);                           // R5
            AST_LOW_RELOAD: assert property (@(posedge clk) disable iff (rst)
                (clr_i && live_i) |=> q);                         // R5
        end else begin : g_high
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= live_i | (q & ~clr_i);
            end

            AST_HIGH_CAPTURE: assert property (@(posedge clk) disable iff (rst)
                live_i |=> q);                                    // R6
            AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
                (q && !clr_i) |=> q);                             // R3
            AST_HIGH_CLEAR: assert property (@(posedge clk) disable iff (rst)
                (clr_i && !live_i) |=> !q);                       // R4
        end
    endgenerate

    assign q_o = q;
endmodule

// File: rtl/phy_id_regs.sv
module phy_id_regs
    import phy_stat_pkg::*;
#(
    parameter reg_word_t ID_HI = ID_HI_WORD,
    parameter logic [5:0] OUI_T = OUI_TAIL,
    parameter logic [5:0] MODEL = MODEL_NUM,
    parameter logic [3:0] REV   = REVISION
) (
    input  reg_sel_t  sel_i,
    output reg_word_t word_o
);
    localparam reg_word_t ID_LO = {OUI_T, MODEL, REV};

    always_comb begin
        case (sel_i)
            SEL_ID_HI: word_o = ID_HI;
            SEL_ID_LO: word_o = ID_LO;
            default:   word_o = '0;
        endcase
    end
endmodule

// File: rtl/phy_mgmt_status.sv
module phy_mgmt_status
    import phy_stat_pkg::*;
#(
    parameter logic [5:0] ABILITY = 6'b011110
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_stb,
    input  logic [4:0]  rd_addr,
    input  logic        link_ok_in,
    input  logic        an_done_in,
    input  logic        fault_in,
    input  logic        jabber_in,
    input  logic        an_enable_in,
    output logic [15:0] rd_data,
    output logic        rd_valid
);
    reg_sel_t    sel;
    logic        stat_clr;
    logic        q_fault, q_jab, q_link;
    stat_flags_t flags;
    reg_word_t   id_word;
    reg_word_t   next_word;

    assign sel      = decode_addr(rd_addr);
    assign stat_clr = rd_stb && (sel == SEL_STATUS);

    phy_stat_sticky #(.HOLD_LOW(1'b0)) u_fault (
        .clk(clk), .rst(rst), .live_i(fault_in), .clr_i(stat_clr), .q_o(q_fault));
    phy_stat_sticky #(.HOLD_LOW(1'b0)) u_jab (
        .clk(clk), .rst(rst), .live_i(jabber_in), .clr_i(stat_clr), .q_o(q_jab));
    phy_stat_sticky #(.HOLD_LOW(1'b1)) u_link (
        .clk(clk), .rst(rst), .live_i(link_ok_in), .clr_i(stat_clr), .q_o(q_link));

    phy_id_regs u_ids (.sel_i(sel), .word_o(id_word));

    always_comb begin
        flags.an_done = an_done_in;
        flags.rfault  = q_fault;
        flags.an_able = an_enable_in;
        flags.link    = q_link;
        flags.jabber  = q_jab;
        if (sel == SEL_STATUS) next_word = pack_status(ABILITY, flags);
        else                   next_word = id_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= next_word;
        end
    end

    AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rd_valid);                                             // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> !rd_valid);                                           // R2
    AST_ID_HI: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_addr == 5'd2) |=> rd_data == 16'h000E);             // R8
    AST_ID_LO: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_addr == 5'd3) |=> rd_data == 16'h70C9);             // R9
    AST_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && (rd_addr == 5'd0 || rd_addr > 5'd3)) |=> rd_data == 16'h0000); // R10
    AST_CONST_BITS: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_addr == 5'd1) |=> (rd_data[0] && rd_data[9:6] == 4'b0000
                                          && rd_data[15:10] == ABILITY)); // R7
    AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_addr == 5'd1 && q_fault) |=> rd_data[4]);           // R6
endmodule

// File: tb/phy_mgmt_status_test.sv
module phy_mgmt_status_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        rd_stb;
    logic [4:0]  rd_addr;
    logic        link_ok_in, an_done_in, fault_in, jabber_in, an_enable_in;
    logic [15:0] rd_data;
    logic        rd_valid;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    logic m_fault, m_jab, m_link;

    always #4 clk = ~clk;

    phy_mgmt_status uut (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .link_ok_in(link_ok_in), .an_done_in(an_done_in), .fault_in(fault_in),
        .jabber_in(jabber_in), .an_enable_in(an_enable_in),
        .rd_data(rd_data), .rd_valid(rd_valid));

    function automatic logic [15:0] exp_word(logic [4:0] a);
        case (a)
            5'd1: return {6'b011110, 4'b0000, an_done_in, m_fault, an_enable_in,
                          m_link, m_jab, 1'b1};
            5'd2: return 16'h000E;
            5'd3: return 16'h70C9;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        logic clr;
        @(posedge clk);
        clr = rd_stb && rd_addr == 5'd1 && !rst;
        if (rst) begin
            m_fault = 0; m_jab = 0; m_link = 0;
        end else begin
            m_fault = fault_in | (m_fault & ~clr);
            m_jab   = jabber_in | (m_jab & ~clr);
            m_link  = clr ? link_ok_in : (m_link & link_ok_in);
        end
        @(negedge clk);
    endtask

    task automatic do_read(logic [4:0] a, string req);
        logic [15:0] e;
        rd_stb = 1; rd_addr = a;
        e = exp_word(a);
        tick();
        rd_stb = 0; fault_in = 0; jabber_in = 0;
        check(req, {15'd0, rd_valid}, 16'd1);
        check(req, rd_data, e);
    endtask

    initial begin
        rst = 1; rd_stb = 0; rd_addr = 0;
        link_ok_in = 1; an_done_in = 0; fault_in = 0; jabber_in = 0; an_enable_in = 1;
        m_fault = 0; m_jab = 0; m_link = 0;
        @(negedge clk);
        tick(); tick();
        rst = 0;
        check("R1 valid low", {15'd0, rd_valid}, 16'd0);
        do_read(5'd1, "R1 reset status");
        check("R1 history bits", rd_data & 16'h0016, 16'h0000);

        // R5: link drop latched across recovery
        do_read(5'd1, "R5 link reload");
        link_ok_in = 0; tick(); link_ok_in = 1; tick(); tick();
        do_read(5'd1, "R5 drop held");
        check("R5 bit2 low", {15'd0, rd_data[2]}, 16'd0);
        do_read(5'd1, "R5 after read");
        check("R5 bit2 high", {15'd0, rd_data[2]}, 16'd1);

        // R3 / R6: fault in the clearing read cycle
        fault_in = 1; tick(); fault_in = 0; tick();
        check("R2 idle valid", {15'd0, rd_valid}, 16'd0);
        fault_in = 1;
        do_read(5'd1, "R6 pre-clear value");
        check("R3 fault seen", {15'd0, rd_data[4]}, 16'd1);
        do_read(5'd1, "R6 event wins");
        check("R6 bit4 kept", {15'd0, rd_data[4]}, 16'd1);
        do_read(5'd1, "R3 cleared");
        check("R3 bit4 clear", {15'd0, rd_data[4]}, 16'd0);

        // R4 jabber and R10 unmapped read keeps it
        jabber_in = 1; tick(); jabber_in = 0;
        do_read(5'd7, "R10 unmapped");
        do_read(5'd31, "R10 top address");
        do_read(5'd1, "R4 jabber held");
        check("R4 bit1", {15'd0, rd_data[1]}, 16'd1);

        // R7 live bits
        an_done_in = 1; an_enable_in = 0;
        do_read(5'd1, "R7 live bits");
        an_enable_in = 1;

        do_read(5'd2, "R8 id high");
        do_read(5'd3, "R9 id low");
        do_read(5'd0, "R10 address zero");

        void'($urandom(32'd2024));
        for (int i = 0; i < 2000; i++) begin
            link_ok_in   = ($urandom % 8) != 0;
            an_done_in   = $urandom % 2;
            an_enable_in = $urandom % 2;
            fault_in     = ($urandom % 10) == 0;
            jabber_in    = ($urandom % 10) == 0;
            if ($urandom % 3 == 0) begin
                logic [4:0] a;
                a = ($urandom % 2) ? 5'd1 : 5'($urandom);
                do_read(a, "R2 random read");
            end else begin
                tick();
                check("R2 random idle", {15'd0, rd_valid}, 16'd0);
            end
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule